// File: doc/BRIEF.md
# Phase-Accumulator Oscillator with One-Bit Density Output

This block is a numerically controlled oscillator. A 32-bit phase register (width set by a parameter) adds a stored frequency word on every clock. The output frequency is therefore fclk × word / 2^ACC_W, and the frequency step is fclk / 2^ACC_W. With the default width and a 42.94967296 MHz clock, one step of the word is exactly 0.01 Hz. To reach a target frequency, software loads word = round(2^ACC_W × fout / fclk). The word is taken only on a load strobe, and the phase is never restarted, so a retune does not break the waveform.

The block has three outputs. The first is a square wave, which is the top phase bit. It has the exact average frequency, but its edges can sit one clock early or late. The second is a 12-bit sample, either a triangle or a sawtooth depending on the mode input. The third is a one-bit pulse-density stream from a first-order error-feedback modulator, driven by that sample. After an external low-pass filter, this stream replaces a multi-bit DAC.

Top module: `dds_sd_osc`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the phase, the stored word and the modulator. After that edge, sq_out, ds_out and wave_out all read 0.
- R2: On every clock out of reset, the phase grows by the stored word modulo 2^ACC_W. The square output therefore has an average period of 2^ACC_W / word clocks.
- R3: A word computed as round(2^ACC_W × fout / fclk) gives a measured rising-edge count and average period that match fout to within one edge over the measurement window.
- R4: sq_out equals the phase MSB. Every period between its rising edges is either floor or ceil of 2^ACC_W / word clocks, so the edge jitter is at most one clock.
- R5: tw_in is ignored on any clock where tw_load is low. The stored word, and with it every output, is unaffected by it.
- R6: A word loaded at clock edge k is first added at edge k+1. Edge k still adds the old word, and the phase is not cleared, so the output stays phase-continuous.
- R7: A loaded word with bit ACC_W-1 set (so fout would be fclk/2 or higher) is stored as 2^(ACC_W-1) − 1.
- R8: With mode = 0, wave_out is a triangle. It is taken from the top 13 phase bits T[12:0] and equals T[11:0], or ~T[11:0] when T[12] is 1.
- R9: With mode = 1, wave_out is a sawtooth equal to the top 12 phase bits.
- R10: The modulator keeps a 12-bit residue. Each clock it adds wave_out to the residue. ds_out becomes the carry out of bit 11, and the residue keeps the lower 12 bits. ds_out therefore lags the sample by one clock.
- R11: Over any 4096 consecutive clocks, the number of ones on ds_out, multiplied by 4096, differs from the sum of the samples fed in by at most 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tw_in | input | ACC_W | Frequency word to load |
| tw_load | input | 1 | Load strobe for tw_in |
| mode | input | 1 | Sample shape: 0 triangle, 1 sawtooth |
| sq_out | output | 1 | Square wave (phase MSB) |
| wave_out | output | SAMP_W | Multi-bit waveform sample |
| ds_out | output | 1 | One-bit pulse-density stream |

## Verification
Some properties are checked by assertions on every cycle:
- the per-clock phase step;
- the hold of the stored word without a strobe;
- the clamp on oversized words;
- the reset values;
- the bound that keeps the stored word below half the phase range.

Other behaviour needs the bench's scenarios. The measured frequency for a computed word, the one-clock bound on square-wave edge jitter, and the ones density over a 4096-clock window each need a long run. So do phase continuity across a retune and the exact triangle and sawtooth encodings, which are compared against a reference model in the bench.

// File: rtl/dds_sd_osc.sv
module dds_sd_osc #(
  parameter int ACC_W  = 32,
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  tw_in,
  input  logic              tw_load,
  input  logic              mode,
  output logic              sq_out,
  output logic [SAMP_W-1:0] wave_out,
  output logic              ds_out
);

  localparam logic [ACC_W-1:0] TW_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W-1:0]  phase_q;
  logic [ACC_W-1:0]  tw_q;
  logic [SAMP_W-1:0] resid_q;

  logic [SAMP_W:0]   top_bits;
  logic [SAMP_W-1:0] tri_s;
  logic [SAMP_W-1:0] saw_s;
  logic [SAMP_W:0]   ds_sum;

  assign top_bits = phase_q[ACC_W-1 -: SAMP_W+1];
  assign tri_s    = top_bits[SAMP_W] ? ~top_bits[SAMP_W-1:0] : top_bits[SAMP_W-1:0];
  assign saw_s    = phase_q[ACC_W-1 -: SAMP_W];
  assign wave_out = mode ? saw_s : tri_s;
  assign sq_out   = phase_q[ACC_W-1];
  assign ds_sum   = {1'b0, resid_q} + {1'b0, wave_out};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tw_q    <= '0;
      resid_q <= '0;
      ds_out  <= 1'b0;
    end else begin
      phase_q <= phase_q + tw_q;
      if (tw_load)
        tw_q <= tw_in[ACC_W-1] ? TW_MAX : tw_in;
      resid_q <= ds_sum[SAMP_W-1:0];
      ds_out  <= ds_sum[SAMP_W];
    end
  end

endmodule

// File: rtl/dds_sd_osc_chk.sv
module dds_sd_osc_chk #(
  parameter int ACC_W  = 32,
  parameter int SAMP_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ACC_W-1:0]  tw_in,
  input logic              tw_load,
  input logic [ACC_W-1:0]  tw_q,
  input logic [ACC_W-1:0]  phase_q,
  input logic              sq_out,
  input logic [SAMP_W-1:0] wave_out,
  input logic              ds_out
);

  localparam logic [ACC_W-1:0] CLAMP = {1'b0, {(ACC_W-1){1'b1}}};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!sq_out && !ds_out && wave_out == '0)); // R1

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_q == $past(phase_q) + $past(tw_q))); // R2

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tw_load |=> $stable(tw_q)); // R5

  AST_WORD_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (tw_load && tw_in[ACC_W-1]) |=> (tw_q == CLAMP)); // R7

  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !tw_q[ACC_W-1]); // R7

endmodule

bind dds_sd_osc dds_sd_osc_chk #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst(rst), .tw_in(tw_in), .tw_load(tw_load), .tw_q(tw_q),
  .phase_q(phase_q), .sq_out(sq_out), .wave_out(wave_out), .ds_out(ds_out)
);

// File: tb/tb_dds_sd_osc.sv
`timescale 1ns/1ps
module tb_dds_sd_osc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tw_in = '0;
  logic        tw_load = 1'b0;
  logic        mode = 1'b0;
  logic        sq_out;
  logic [11:0] wave_out;
  logic        ds_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 0;

  logic [31:0] m_phase, m_tw;
  logic [11:0] m_acc;
  logic        m_ds;

  always #2 clk = ~clk;

  dds_sd_osc dut (
    .clk(clk), .rst(rst), .tw_in(tw_in), .tw_load(tw_load), .mode(mode),
    .sq_out(sq_out), .wave_out(wave_out), .ds_out(ds_out)
  );

  function automatic logic [31:0] sat(input logic [31:0] w);
    return w[31] ? 32'h7FFF_FFFF : w;
  endfunction

  function automatic logic [11:0] samp(input logic [31:0] ph, input logic md);
    logic [12:0] t;
    t = ph[31:19];
    if (md) return ph[31:20];
    return t[12] ? ~t[11:0] : t[11:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    chk(sq_out == m_phase[31], "R4 square is phase MSB", sq_out, m_phase[31]);
    chk(wave_out == samp(m_phase, mode), mode ? "R9 sawtooth sample" : "R8 triangle sample",
        wave_out, samp(m_phase, mode));
    chk(ds_out == m_ds, "R10 modulator bit", ds_out, m_ds);
  endtask

  task automatic step(input logic ld, input logic [31:0] w, input logic md);
    logic [12:0] s;
    tw_load = ld; tw_in = w; mode = md;
    @(posedge clk);
    s = {1'b0, m_acc} + {1'b0, samp(m_phase, md)};
    m_ds = s[12]; m_acc = s[11:0];
    m_phase = m_phase + m_tw;
    if (ld) m_tw = sat(w);
    @(negedge clk);
    tw_load = 1'b0;
    check_outs();
  endtask

  task automatic do_reset();
    rst = 1'b1; tw_load = 1'b0;
    @(posedge clk);
    m_phase = '0; m_tw = '0; m_acc = '0; m_ds = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(sq_out == 1'b0, "R1 sq_out after reset", sq_out, 0);
    chk(ds_out == 1'b0, "R1 ds_out after reset", ds_out, 0);
    chk(wave_out == 12'd0, "R1 wave_out after reset", wave_out, 0);
  endtask

  task automatic density(input logic [31:0] w, input logic md);
    longint ssum, ones, diff;
    step(1'b1, w, md);
    step(1'b0, 32'd0, md);
    ssum = wave_out; ones = 0;
    for (int i = 0; i < 4096; i++) begin
      step(1'b0, 32'd0, md);
      ones += ds_out;
      if (i < 4095) ssum += wave_out;
    end
    diff = ones * 4096 - ssum;
    if (diff < 0) diff = -diff;
    chk(diff <= 4096, "R11 ones density over 4096 clocks", ones * 4096, ssum);
  endtask

  initial begin
    logic [31:0] w_freq, saved;
    longint last_edge, first_edge, n_edges, lo_p, hi_p, span, err;
    int bad_period;
    logic prev_sq;
    void'($urandom(32'd20240611));
    do_reset();

    // R5: tw_in without strobe is ignored
    for (int i = 0; i < 8; i++) step(1'b0, 32'h1234_5678 + i, 1'b0);
    chk(wave_out == 12'd0 && sq_out == 1'b0, "R5 word ignored without strobe", wave_out, 0);

    // R7: clamp of oversized word
    step(1'b1, 32'hFFFF_FFFF, 1'b1);
    step(1'b0, 32'd0, 1'b1);
    chk(sq_out == 1'b0 && wave_out == 12'h7FF, "R7 clamped step 1", wave_out, 12'h7FF);
    step(1'b0, 32'd0, 1'b1);
    chk(sq_out == 1'b1 && wave_out == 12'hFFF, "R7 clamped step 2", wave_out, 12'hFFF);
    step(1'b1, 32'h8000_0000, 1'b0);
    step(1'b0, 32'd0, 1'b0);

    // R3/R4/R2: frequency from computed word, fout = fclk/100
    do_reset();
    w_freq = 32'd42949673;
    step(1'b1, w_freq, 1'b0);
    lo_p = 64'h1_0000_0000 / w_freq; hi_p = lo_p + 1;
    prev_sq = sq_out; n_edges = 0; bad_period = 0; last_edge = -1; first_edge = -1;
    for (int c = 0; c < 20000; c++) begin
      step(1'b0, 32'd0, 1'b0);
      if (sq_out && !prev_sq) begin
        if (last_edge >= 0 && !((c - last_edge) == lo_p || (c - last_edge) == hi_p)) begin
          bad_period++;
          chk(0, "R4 edge period", c - last_edge, lo_p);
        end
        if (first_edge < 0) first_edge = c;
        last_edge = c;
        n_edges++;
      end
      prev_sq = sq_out;
    end
    chk(bad_period == 0, "R4 all periods floor or ceil", bad_period, 0);
    chk(n_edges >= 199 && n_edges <= 201, "R3 rising edge count", n_edges, 200);
    span = (last_edge - first_edge) * longint'(w_freq);
    err = span - (n_edges - 1) * 64'h1_0000_0000;
    if (err < 0) err = -err;
    chk(err <= longint'(w_freq), "R2 average period matches word", span, (n_edges - 1) * 64'h1_0000_0000);

    // R6: retune mid-run keeps phase
    saved = m_phase;
    step(1'b1, 32'h0100_0000, 1'b1);
    chk(wave_out == samp(saved + w_freq, 1'b1), "R6 old word used on load edge", wave_out, samp(saved + w_freq, 1'b1));
    step(1'b0, 32'd0, 1'b1);
    chk(wave_out == samp(saved + w_freq + 32'h0100_0000, 1'b1), "R6 new word next edge",
        wave_out, samp(saved + w_freq + 32'h0100_0000, 1'b1));

    // R11: density at several levels
    do_reset(); density(32'h3000_0000, 1'b1);
    do_reset(); density(32'h5555_1234, 1'b0);
    do_reset(); density(32'h0000_0000, 1'b0);

    // Random mix: R2/R5/R7/R8/R9/R10
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic ld;
      ld = ($urandom % 16) == 0;
      step(ld, $urandom, logic'($urandom % 2));
    end

    // R1: reset in mid-run
    step(1'b1, 32'h2345_6789, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 32'd0, 1'b0);
    do_reset();
    step(1'b0, 32'd0, 1'b0);
    chk(wave_out == 12'd0, "R1 word cleared by reset", wave_out, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule